// File: doc/BRIEF.md
# Configurable SPI Master Shift Engine

This block is the serial core of a single-select SPI master. When it is enabled and the transmit FIFO in front of it holds a word, it pops that word and runs one frame. During the frame it asserts the frame (chip-select) line, drives the serial clock from a divided system clock, shifts the word out on MOSI and samples MISO. At the end of the frame it pushes one received word into the receive FIFO behind it. The FIFOs themselves, the register file and any interrupt logic sit outside the block.

Four independent settings fix the clock waveform:
- the idle level of the serial clock;
- the edge on which MISO is captured;
- an optional start delay;
- the frame-start edge, which also decides how long that delay is.

Further settings select the frame polarity, a word length from 1 to 32 bits and the bit order. The engine takes a snapshot of the settings when it pops a word, so it does not depend on them during the frame. Both FIFOs are first-word-fall-through: `tx_word` is valid whenever `tx_empty` is low.

Top module: `spi_shift_engine`

## Requirements
- R1: The serial clock half period is H system cycles. H is `clk_ratio` divided by two and rounded down, with a minimum of 2, so each even ratio from 4 to 254 gives a full serial period of exactly `clk_ratio` cycles. A frame toggles the clock 2·W times, where W is the word length.
- R2: Outside a frame `sclk` rests at `idle_high` (0 gives low, 1 gives high). Each frame also starts and ends at that level.
- R3: With `capture_fall`=0, MISO is sampled on every rising `sclk` edge of the frame. With `capture_fall`=1 it is sampled on every falling edge. The value sampled is the one present in the system cycle before the edge appears on `sclk`.
- R4: The first `sclk` edge appears after the frame asserts by the following number of half periods:
  - 1 when `start_delay`=0;
  - 2 when `start_delay`=1 and `frame_on_fall`=1 (half a serial period of extra delay);
  - 3 when `start_delay`=1 and `frame_on_fall`=0 (a full serial period of extra delay).
  The frame stays asserted for one half period after the last edge.
- R5: The `frame` pin is active high when `frame_act_high`=1 and active low when it is 0.
- R6: W follows `word_len`. Values 1 to 32 are used as given, 0 is treated as 1, and values above 32 are treated as 32. Transmit bits above W are never sent.
- R7: When `bit_order` equals 1, the word goes out and comes back LSB-first. Any other value (0, 2, 3) gives MSB-first.
- R8: During reset, and from the cycle after `enable` is seen low, no frame is active: `sclk` sits at its idle level and `frame` is inactive. Dropping `enable` during a frame abandons that frame without a push, and no word is popped while `enable` is low.
- R9: `tx_pop` is high for one cycle only when `enable` is high, `tx_empty` is low and no frame is active. `tx_word` is taken in that cycle, and the frame asserts in the next cycle.
- R10: A finished frame raises `rx_push` for exactly one cycle. This is the same cycle in which `frame` goes inactive. In that cycle `rx_word` holds the W received bits right-aligned, with zeros above them. A new pop may happen in that same cycle.
- R11: MOSI shows the first bit from the cycle the frame asserts. It advances to the next bit only on clock edges that are not capture edges and that come after the first capture of the frame. Outside a frame MOSI is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global enable for the engine |
| clk_ratio | input | RATIO_W | System cycles per serial clock period (even values from 4 to 254) |
| idle_high | input | 1 | Resting level of the serial clock |
| capture_fall | input | 1 | 0 captures MISO on rising edges, 1 on falling edges |
| start_delay | input | 1 | Holds back the first clock edge |
| frame_on_fall | input | 1 | Frame-start edge; also selects a delay of half a period (1) or a full period (0) |
| frame_act_high | input | 1 | Frame polarity: 1 for active high |
| word_len | input | LEN_W | Bits per word |
| bit_order | input | 2 | 1 selects LSB-first; any other value selects MSB-first |
| tx_empty | input | 1 | The transmit FIFO is empty |
| tx_word | input | MAX_BITS | Head of the transmit FIFO |
| tx_pop | output | 1 | Takes the head word of the transmit FIFO |
| rx_push | output | 1 | Writes `rx_word` into the receive FIFO; also the one-cycle word-done pulse |
| rx_word | output | MAX_BITS | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| frame | output | 1 | Frame / chip-select line |
| miso | input | 1 | Serial data in |

## Verification
The assertions assume that `idle_high` and `frame_act_high` do not change in the cycle of a push or while a frame is active. The bench changes every setting only while `enable` is low and the engine is idle, and then holds the settings until the queued words have drained. MISO changes at most once per system cycle, just after the rising clock edge, and follows a fixed hash of the cycle number. This lets the reference model predict every captured bit from cycle numbers alone. The stimulus covers all four knob combinations that match the standard SPI modes, ratios at the extremes and below the legal range, word lengths of 0, 1, 5, 8, 16, 32 and 40, all bit-order codes, back-to-back frames, a word that waits while the engine is disabled, and a frame abandoned partway through.

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int MAX_BITS = 32,
  parameter int RATIO_W  = 8,
  parameter int LEN_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [RATIO_W-1:0]  clk_ratio,
  input  logic                idle_high,
  input  logic                capture_fall,
  input  logic                start_delay,
  input  logic                frame_on_fall,
  input  logic                frame_act_high,
  input  logic [LEN_W-1:0]    word_len,
  input  logic [1:0]          bit_order,
  input  logic                tx_empty,
  input  logic [MAX_BITS-1:0] tx_word,
  output logic                tx_pop,
  output logic                rx_push,
  output logic [MAX_BITS-1:0] rx_word,
  output logic                sclk,
  output logic                mosi,
  output logic                frame,
  input  logic                miso
);

  localparam int HALF_W = RATIO_W - 1;
  localparam int CNT_W  = $clog2(2 * MAX_BITS + 4);

  function automatic logic [MAX_BITS-1:0] low_mask(input logic [LEN_W-1:0] n);
    return {MAX_BITS{1'b1}} >> (MAX_BITS - int'(n));
  endfunction

  logic                busy, sclk_q, cap_seen;
  logic [HALF_W-1:0]   hcnt, half_q;
  logic [CNT_W-1:0]    tk;
  logic [MAX_BITS-1:0] sh_tx, sh_rx;
  logic [LEN_W-1:0]    len_q;
  logic [1:0]          lead_q;
  logic                lsb_q, capf_q;

  logic [LEN_W-1:0]    len_in;
  logic [HALF_W-1:0]   half_in;
  logic [1:0]          lead_in;
  logic                lsb_in;
  logic [CNT_W-1:0]    tk_nxt, end_tick;

  assign len_in  = (word_len == '0) ? LEN_W'(1)
                 : (int'(word_len) > MAX_BITS) ? LEN_W'(MAX_BITS) : word_len;
  assign half_in = (clk_ratio[RATIO_W-1:1] < HALF_W'(2)) ? HALF_W'(2) : clk_ratio[RATIO_W-1:1];
  assign lead_in = start_delay ? (frame_on_fall ? 2'd1 : 2'd2) : 2'd0;
  assign lsb_in  = (bit_order == 2'd1);

  assign tk_nxt   = tk + CNT_W'(1);
  assign end_tick = CNT_W'(lead_q) + CNT_W'({len_q, 1'b0}) + CNT_W'(1);

  assign tx_pop = !busy && enable && !tx_empty;
  assign sclk   = busy ? sclk_q : idle_high;
  assign frame  = frame_act_high ? busy : !busy;
  assign mosi   = busy && (lsb_q ? sh_tx[0] : sh_tx[MAX_BITS-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sclk_q   <= 1'b0;
      cap_seen <= 1'b0;
      hcnt     <= '0;
      half_q   <= HALF_W'(2);
      tk       <= '0;
      sh_tx    <= '0;
      sh_rx    <= '0;
      len_q    <= LEN_W'(1);
      lead_q   <= 2'd0;
      lsb_q    <= 1'b0;
      capf_q   <= 1'b0;
      rx_push  <= 1'b0;
      rx_word  <= '0;
    end else begin
      rx_push <= 1'b0;
      if (!busy) begin
        if (tx_pop) begin
          busy     <= 1'b1;
          hcnt     <= '0;
          tk       <= '0;
          cap_seen <= 1'b0;
          sclk_q   <= idle_high;
          half_q   <= half_in;
          len_q    <= len_in;
          lead_q   <= lead_in;
          lsb_q    <= lsb_in;
          capf_q   <= capture_fall;
          sh_rx    <= '0;
          sh_tx    <= lsb_in ? (tx_word & low_mask(len_in))
                             : (tx_word << (MAX_BITS - int'(len_in)));
        end
      end else if (!enable) begin
        busy <= 1'b0;
      end else if (hcnt == half_q - HALF_W'(1)) begin
        hcnt <= '0;
        tk   <= tk_nxt;
        if (tk_nxt == end_tick) begin
          busy    <= 1'b0;
          rx_push <= 1'b1;
          rx_word <= lsb_q ? (sh_rx >> (MAX_BITS - int'(len_q))) : sh_rx;
        end else if (tk_nxt > CNT_W'(lead_q)) begin
          sclk_q <= !sclk_q;
          if ((!sclk_q) != capf_q) begin
            cap_seen <= 1'b1;
            sh_rx    <= lsb_q ? {miso, sh_rx[MAX_BITS-1:1]} : {sh_rx[MAX_BITS-2:0], miso};
          end else if (cap_seen) begin
            sh_tx <= lsb_q ? (sh_tx >> 1) : (sh_tx << 1);
          end
        end
      end else begin
        hcnt <= hcnt + HALF_W'(1);
      end
    end
  end

endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic idle_high,
  input logic frame_act_high,
  input logic tx_empty,
  input logic tx_pop,
  input logic rx_push,
  input logic sclk,
  input logic frame,
  input logic mosi
);

  logic in_frame;
  assign in_frame = (frame == frame_act_high);

  a_r8_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (sclk == idle_high) && !in_frame);

  a_r9_pop_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> (enable && !tx_empty));

  a_r9_no_pop_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    in_frame |-> !tx_pop);

  a_r10_push_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rx_push);

  a_r10_push_closes_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> (!in_frame && $past(in_frame)));

  a_r2_sclk_rests: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frame |-> (sclk == idle_high));

  a_r11_mosi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frame |-> !mosi);

endmodule

bind spi_shift_engine spi_shift_engine_chk u_chk (.*);

// File: tb/tb_spi_shift_engine.sv
module tb_spi_shift_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  clk_ratio = 8'd4;
  logic        idle_high = 1'b0, capture_fall = 1'b0, start_delay = 1'b0;
  logic        frame_on_fall = 1'b0, frame_act_high = 1'b0;
  logic [5:0]  word_len = 6'd8;
  logic [1:0]  bit_order = 2'd0;
  logic        tx_empty = 1'b1;
  logic [31:0] tx_word = '0;
  logic        tx_pop, rx_push, sclk, mosi, frame;
  logic [31:0] rx_word;
  logic        miso = 1'b0;

  spi_shift_engine dut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] txq[$];
  bit pop_pend = 0;

  function automatic logic hbit(int n);
    logic [31:0] x;
    x = n * 32'h9E3779B1;
    return x[17] ^ x[5];
  endfunction

  task automatic refresh_tx();
    tx_empty = (txq.size() == 0);
    tx_word  = (txq.size() == 0) ? 32'h0 : txq[0];
  endtask

  always @(posedge clk) cyc = cyc + 1;

  always @(posedge clk) begin
    #1;
    miso = hbit(cyc);
    if (pop_pend) begin
      void'(txq.pop_front());
      pop_pend = 0;
      refresh_tx();
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle=%0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  // reference model
  bit act = 0, kill = 0;
  int t0, tend, hh, dd, ww, m_idle, m_capf, m_lsb;
  logic [31:0] m_word, m_rx;

  always @(negedge clk) begin
    int n, j, ne, b, lvl;
    bit busy_m, exp_pop, exp_push, cs, e_sclk, e_frame, e_mosi;
    n = cyc;
    if (!rst_n) begin
      chk(sclk == idle_high, "R8 reset sclk", 32'(sclk), 32'(idle_high));
      chk(frame == !frame_act_high, "R8 reset frame", 32'(frame), 32'(!frame_act_high));
      chk(!tx_pop && !rx_push, "R8 reset pop/push", {tx_pop, rx_push}, 0);
    end else begin
      if (kill) begin act = 0; kill = 0; end
      busy_m   = act && (n < tend);
      exp_push = act && (n == tend);
      exp_pop  = !busy_m && enable && !tx_empty;
      e_sclk = idle_high; e_mosi = 0;
      if (busy_m) begin
        j  = (n - t0) / hh;
        ne = j - dd;
        if (ne < 0) ne = 0;
        if (ne > 2 * ww) ne = 2 * ww;
        e_sclk = 1'(m_idle ^ (ne & 1));
        b = 0; cs = 0;
        for (int k = 0; k < ne; k++) begin
          lvl = m_idle ^ ((k + 1) & 1);
          if (lvl != m_capf) cs = 1;
          else if (cs) b++;
        end
        if (b < ww) e_mosi = m_lsb ? m_word[b] : m_word[ww-1-b];
      end
      e_frame = frame_act_high ? busy_m : !busy_m;
      chk(tx_pop == exp_pop, "R9 tx_pop", 32'(tx_pop), 32'(exp_pop));
      chk(sclk == e_sclk, "R1 R2 R4 sclk", 32'(sclk), 32'(e_sclk));
      chk(frame == e_frame, "R5 R8 frame", 32'(frame), 32'(e_frame));
      chk(mosi == e_mosi, "R6 R7 R11 mosi", 32'(mosi), 32'(e_mosi));
      chk(rx_push == exp_push, "R10 rx_push", 32'(rx_push), 32'(exp_push));
      if (exp_push && rx_push)
        chk(rx_word == m_rx, "R3 R6 R7 R10 rx_word", rx_word, m_rx);
      if (exp_push) act = 0;
      if (busy_m && !enable) kill = 1;
      if (exp_pop) begin
        act    = 1;
        t0     = n + 1;
        ww     = (word_len == 0) ? 1 : ((word_len > 32) ? 32 : int'(word_len));
        hh     = (int'(clk_ratio) / 2 < 2) ? 2 : int'(clk_ratio) / 2;
        dd     = start_delay ? (frame_on_fall ? 1 : 2) : 0;
        m_idle = int'(idle_high);
        m_capf = int'(capture_fall);
        m_lsb  = (bit_order == 2'd1) ? 1 : 0;
        m_word = tx_word;
        tend   = t0 + (dd + 2 * ww + 1) * hh;
        m_rx = '0; b = 0;
        for (int k = 0; k < 2 * ww; k++) begin
          lvl = m_idle ^ ((k + 1) & 1);
          if (lvl != m_capf) begin
            if (m_lsb) m_rx[b] = hbit(t0 + (dd + 1 + k) * hh - 1);
            else       m_rx[ww-1-b] = hbit(t0 + (dd + 1 + k) * hh - 1);
            b++;
          end
        end
        pop_pend = 1;
      end
    end
  end

  task automatic setup(int ratio, bit idl, bit capf, bit dly, bit fst, bit pol, int len, int ord);
    @(posedge clk); #2;
    enable = 0;
    @(posedge clk); #2;
    clk_ratio = 8'(ratio); idle_high = idl; capture_fall = capf; start_delay = dly;
    frame_on_fall = fst; frame_act_high = pol; word_len = 6'(len); bit_order = 2'(ord);
  endtask

  task automatic drain();
    @(posedge clk); #2;
    enable = 1;
    do begin
      @(negedge clk); #2;
    end while (txq.size() != 0 || act || pop_pend);
    repeat (3) @(posedge clk);
  endtask

  task automatic push(logic [31:0] w);
    txq.push_back(w);
    refresh_tx();
  endtask

  initial begin
    int wd_done;
    repeat (4) @(posedge clk);
    #2 rst_n = 1;
    // R2 R4 R3: capture falling, idle low, full-period delay
    setup(4, 0, 1, 1, 0, 0, 8, 0);  push(32'hA5); push(32'h3C); drain();
    // R7 R5 R6: LSB-first, active-high frame, high bits beyond W ignored
    setup(6, 0, 0, 0, 1, 1, 16, 1); push(32'hFFFF1234); push(32'h0000BEEF); drain();
    // R4 R7: half-period delay, idle high, order code 2 is MSB-first
    setup(8, 1, 0, 1, 1, 0, 32, 2); push(32'hDEADBEEF); drain();
    // R6: one-bit words, order code 3
    setup(10, 1, 1, 0, 0, 1, 1, 3); push(32'h1); push(32'h0); push(32'hFFFFFFFE); drain();
    // R6: length 0 acts as 1, ratio below range acts as 4
    setup(2, 0, 0, 0, 0, 0, 0, 0); push(32'h1); drain();
    // R6 R1: length above 32 acts as 32, odd ratio rounds down
    setup(7, 0, 1, 1, 0, 0, 40, 1); push(32'h12345678); drain();
    // R1: largest legal ratio
    setup(254, 1, 1, 1, 0, 1, 5, 0); push(32'h15); drain();
    // R9 R10: back-to-back frames at the fastest ratio
    setup(4, 1, 0, 0, 1, 0, 12, 0); push(32'hABC); push(32'h123); push(32'hFFF); push(32'h000); drain();
    // R8: word waits while disabled, then a frame is abandoned mid-way
    setup(20, 0, 1, 1, 0, 0, 32, 0); push(32'hCAFEF00D);
    repeat (50) @(posedge clk);
    #2 enable = 1;
    repeat (200) @(posedge clk);
    #2 enable = 0;
    repeat (40) @(posedge clk);
    push(32'h5A5A5A5A); drain();
    wd_done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule